// File: doc/BRIEF.md
# Masked vector execution unit

This block runs one vector arithmetic instruction at a time, element by element, over a small file of wide vector registers. Software first selects an element width and a vector length. It then issues an instruction that names up to two source registers, a destination register, a scalar operand and an optional predicate. The unit steps through the active elements one per clock. It reports completion with a one-cycle pulse. Any vector or flag register can be read back at any time.

A bank of flag registers holds one bit per element. A not-equal compare fills a flag register. Any writing instruction can then be predicated on a flag register, so that only the elements whose bit is set are changed. The number of elements a register holds depends on the element width: narrower elements give a longer maximum vector length. A halving move copies the upper part of the active vector into the bottom of another register. Repeating add-then-halve with a shrinking vector length folds a whole vector into its first element.

Top module: `mveu_top`

## Requirements
- R1: After reset, busy and done are low, the vector length is 0, the width code is 0, and every vector and flag register reads as zero.
- R2: Width codes 0, 1, 2 and 3 select 64-, 32-, 16- and 8-bit elements. The maximum vector length is REG_BITS divided by the element size, which gives 4, 8, 16 and 32 for the default 256-bit register. A configuration write whose length exceeds that maximum stores the maximum instead.
- R3: An instruction issued while idle raises busy at the next edge. It holds busy for n cycles, where n is the element count, and then drops busy and pulses done for one cycle. When n is 0, done pulses at the first edge and busy stays low. Opcodes 6 and 7 take n cycles and write nothing.
- R4: Destination elements at index VL or above are never modified by any instruction.
- R5: Opcode 0 adds and opcode 1 subtracts (first source minus second source) element-wise. Both wrap modulo the element width.
- R6: Opcode 2 adds the scalar to the first source. Opcode 3 multiplies the first source by the scalar and keeps the low element bits. In both, the scalar is first truncated to the element width.
- R7: Opcode 4 sets flag bit i of the flag destination to 1 when source elements i differ and to 0 when they are equal, for i below VL. Flag bits at VL and above keep their values.
- R8: With the predicate enabled, element i of the destination is written only when bit i of the selected flag register is 1. Otherwise it keeps its old value.
- R9: With the predicate disabled, the flag registers have no effect. Flag register 0 has no special all-ones meaning.
- R10: Opcode 5 writes destination element i with first-source element ceil(VL/2)+i, for i below floor(VL/2). It takes floor(VL/2) cycles.
- R11: Configuration writes and new instructions presented while busy are ignored.
- R12: Element i of a vector register occupies bits [i*E +: E] of the read-back, where E is the element size. Flag bit i is bit i of the flag read-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load width and vector length (idle only) |
| cfg_width | input | 2 | Element width code |
| cfg_vl | input | VLW (6) | Requested vector length |
| issue_valid | input | 1 | Instruction present (accepted when idle) |
| issue_op | input | 3 | Opcode |
| issue_vd | input | VRW (2) | Destination vector register |
| issue_va | input | VRW (2) | First source vector register |
| issue_vb | input | VRW (2) | Second source vector register |
| issue_fd | input | FRW (2) | Flag destination for compare |
| issue_mask_en | input | 1 | Enable predication |
| issue_mask_sel | input | FRW (2) | Predicate flag register |
| issue_scalar | input | 64 | Scalar operand |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_vl | output | VLW (6) | Current vector length |
| cur_width | output | 2 | Current width code |
| rd_vsel | input | VRW (2) | Vector read-back select |
| rd_vdata | output | REG_BITS (256) | Vector read-back |
| rd_fsel | input | FRW (2) | Flag read-back select |
| rd_fdata | output | REG_BITS/8 (32) | Flag read-back |

## Verification
The bench presents an instruction on one falling edge. It then samples at every later falling edge, expecting busy high for exactly n samples and done on sample n, where n is the vector length, half of it for the halving move, or zero. Configuration takes effect at the first rising edge, so cur_vl and cur_width are checked on the following falling edge. Register contents are compared only after done, when every element write has landed. For the ignore-while-busy case, the second instruction and configuration are driven one cycle after the first instruction is accepted.

// File: rtl/mveu_pkg.sv
package mveu_pkg;

   typedef enum logic [2:0] {
      OP_ADDVV = 3'd0,
      OP_SUBVV = 3'd1,
      OP_ADDSV = 3'd2,
      OP_MULSV = 3'd3,
      OP_CMPNE = 3'd4,
      OP_HALVE = 3'd5,
      OP_RSV6  = 3'd6,
      OP_RSV7  = 3'd7
   } vop_e;

   // element mask for a width code (0:64b .. 3:8b)
   function automatic logic [63:0] emask(logic [1:0] w);
      case (w)
         2'd0:    return 64'hFFFF_FFFF_FFFF_FFFF;
         2'd1:    return 64'h0000_0000_FFFF_FFFF;
         2'd2:    return 64'h0000_0000_0000_FFFF;
         default: return 64'h0000_0000_0000_00FF;
      endcase
   endfunction

   // maximum vector length for a register size and width code
   function automatic logic [15:0] mvl_of(int unsigned reg_bits, logic [1:0] w);
      return 16'((reg_bits / 64) << w);
   endfunction

   function automatic logic writes_vreg(vop_e op);
      return (op == OP_ADDVV) || (op == OP_SUBVV) || (op == OP_ADDSV) ||
             (op == OP_MULSV) || (op == OP_HALVE);
   endfunction

endpackage

// File: rtl/mveu_alu.sv
module mveu_alu
   import mveu_pkg::*;
#(
   parameter bit HAS_MUL = 1'b1
) (
   input  vop_e        op,
   input  logic [1:0]  ew,
   input  logic [63:0] a,
   input  logic [63:0] b,
   input  logic [63:0] s,
   output logic [63:0] res,
   output logic        neq
);

   logic [63:0] m;
   logic [63:0] sm;
   logic [63:0] prod;
   logic [63:0] raw;

   assign m  = emask(ew);
   assign sm = s & m;

   generate
      if (HAS_MUL) begin : g_mul
         assign prod = a * sm;
      end else begin : g_nomul
         assign prod = '0;
      end
   endgenerate

   always_comb begin
      case (op)
         OP_ADDVV: raw = a + b;
         OP_SUBVV: raw = a - b;
         OP_ADDSV: raw = sm + a;
         OP_MULSV: raw = prod;
         default:  raw = a;
      endcase
   end

   assign res = raw & m;
   assign neq = (a & m) != (b & m);

endmodule

// File: rtl/mveu_vrf.sv
module mveu_vrf #(
   parameter  int REG_BITS  = 256,
   parameter  int NUM_VREGS = 4,
   localparam int NB        = REG_BITS / 8,
   localparam int IW        = $clog2(NB),
   localparam int VRW       = $clog2(NUM_VREGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          ew,
   input  logic [VRW-1:0]      ra_sel,
   input  logic [IW-1:0]       ra_idx,
   output logic [63:0]         ra_data,
   input  logic [VRW-1:0]      rb_sel,
   input  logic [IW-1:0]       rb_idx,
   output logic [63:0]         rb_data,
   input  logic                we,
   input  logic [VRW-1:0]      w_sel,
   input  logic [IW-1:0]       w_idx,
   input  logic [63:0]         w_data,
   input  logic [VRW-1:0]      rd_sel,
   output logic [REG_BITS-1:0] rd_data
);
   import mveu_pkg::*;

   logic [REG_BITS-1:0] regs [NUM_VREGS];
   logic [REG_BITS-1:0] sha, shb;
   logic [REG_BITS-1:0] wmask, wwide;
   int unsigned         ebits;
   int                  lgb;

   assign ebits = 32'd64 >> ew;
   assign lgb   = 3 - int'(ew);

   assign sha     = regs[ra_sel] >> (32'(ra_idx) * ebits);
   assign shb     = regs[rb_sel] >> (32'(rb_idx) * ebits);
   assign ra_data = sha[63:0] & emask(ew);
   assign rb_data = shb[63:0] & emask(ew);
   assign rd_data = regs[rd_sel];

   // byte lanes covered by the addressed element
   always_comb begin
      wmask = '0;
      wwide = '0;
      for (int b = 0; b < NB; b++) begin
         if ((b >> lgb) == int'(w_idx)) begin
            wmask[b*8 +: 8] = 8'hFF;
            wwide[b*8 +: 8] = w_data[(b & ((1 << lgb) - 1))*8 +: 8];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int v = 0; v < NUM_VREGS; v++) regs[v] <= '0;
      end else if (we) begin
         regs[w_sel] <= (regs[w_sel] & ~wmask) | wwide;
      end
   end

endmodule

// File: rtl/mveu_ffile.sv
module mveu_ffile #(
   parameter  int NUM_FREGS = 4,
   parameter  int FB        = 32,
   localparam int IW        = $clog2(FB),
   localparam int FRW       = $clog2(NUM_FREGS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [FRW-1:0] w_sel,
   input  logic [IW-1:0]  w_idx,
   input  logic           w_bit,
   input  logic [FRW-1:0] m_sel,
   output logic [FB-1:0]  m_data,
   input  logic [FRW-1:0] rd_sel,
   output logic [FB-1:0]  rd_data
);

   logic [FB-1:0] fr [NUM_FREGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int f = 0; f < NUM_FREGS; f++) fr[f] <= '0;
      end else if (we) begin
         fr[w_sel][w_idx] <= w_bit;
      end
   end

   assign m_data  = fr[m_sel];
   assign rd_data = fr[rd_sel];

endmodule

// File: rtl/mveu_top.sv
module mveu_top
   import mveu_pkg::*;
#(
   parameter  int REG_BITS  = 256,
   parameter  int NUM_VREGS = 4,
   parameter  int NUM_FREGS = 4,
   parameter  bit HAS_MUL   = 1'b1,
   localparam int MAX_MVL   = REG_BITS / 8,
   localparam int IW        = $clog2(MAX_MVL),
   localparam int VLW       = $clog2(MAX_MVL + 1),
   localparam int VRW       = $clog2(NUM_VREGS),
   localparam int FRW       = $clog2(NUM_FREGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [1:0]          cfg_width,
   input  logic [VLW-1:0]      cfg_vl,
   input  logic                issue_valid,
   input  logic [2:0]          issue_op,
   input  logic [VRW-1:0]      issue_vd,
   input  logic [VRW-1:0]      issue_va,
   input  logic [VRW-1:0]      issue_vb,
   input  logic [FRW-1:0]      issue_fd,
   input  logic                issue_mask_en,
   input  logic [FRW-1:0]      issue_mask_sel,
   input  logic [63:0]         issue_scalar,
   output logic                busy,
   output logic                done,
   output logic [VLW-1:0]      cur_vl,
   output logic [1:0]          cur_width,
   input  logic [VRW-1:0]      rd_vsel,
   output logic [REG_BITS-1:0] rd_vdata,
   input  logic [FRW-1:0]      rd_fsel,
   output logic [MAX_MVL-1:0]  rd_fdata
);

   generate
      if (REG_BITS < 64 || (REG_BITS % 64) != 0) begin : g_bad_bits
         $error("REG_BITS must be a positive multiple of 64");
      end
      if (NUM_VREGS < 2 || (NUM_VREGS & (NUM_VREGS - 1)) != 0) begin : g_bad_vregs
         $error("NUM_VREGS must be a power of two, at least 2");
      end
      if (NUM_FREGS < 2 || (NUM_FREGS & (NUM_FREGS - 1)) != 0) begin : g_bad_fregs
         $error("NUM_FREGS must be a power of two, at least 2");
      end
   endgenerate

   // configuration state
   logic [VLW-1:0] vl_q;
   logic [1:0]     ew_q;
   logic [VLW-1:0] cfg_cap;
   logic [VLW-1:0] vl_clamped;

   // sequencer state
   logic           busy_q, done_q;
   logic [VLW-1:0] idx_q, last_q, off_q;
   vop_e           op_q;
   logic [1:0]     oew_q;
   logic [VRW-1:0] vd_q, va_q, vb_q;
   logic [FRW-1:0] fd_q, msel_q;
   logic           men_q;
   logic [63:0]    scal_q;

   vop_e           op_in;
   logic [VLW-1:0] n_new;

   assign cfg_cap    = VLW'(mvl_of(REG_BITS, cfg_width));
   assign vl_clamped = (cfg_vl > cfg_cap) ? cfg_cap : cfg_vl;
   assign op_in      = vop_e'(issue_op);
   assign n_new      = (op_in == OP_HALVE) ? (vl_q >> 1) : vl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vl_q   <= '0;
         ew_q   <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
         last_q <= '0;
         off_q  <= '0;
         op_q   <= OP_ADDVV;
         oew_q  <= '0;
         vd_q   <= '0;
         va_q   <= '0;
         vb_q   <= '0;
         fd_q   <= '0;
         msel_q <= '0;
         men_q  <= 1'b0;
         scal_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == last_q) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end else begin
            if (cfg_we) begin
               ew_q <= cfg_width;
               vl_q <= vl_clamped;
            end
            if (issue_valid) begin
               op_q   <= op_in;
               oew_q  <= ew_q;
               vd_q   <= issue_vd;
               va_q   <= issue_va;
               vb_q   <= issue_vb;
               fd_q   <= issue_fd;
               men_q  <= issue_mask_en;
               msel_q <= issue_mask_sel;
               scal_q <= issue_scalar;
               idx_q  <= '0;
               last_q <= n_new - 1'b1;
               off_q  <= vl_q - n_new;
               if (n_new == '0) done_q <= 1'b1;
               else             busy_q <= 1'b1;
            end
         end
      end
   end

   // datapath
   logic [IW-1:0]      a_idx, e_idx;
   logic [63:0]        a_data, b_data, alu_res;
   logic               alu_neq;
   logic [MAX_MVL-1:0] m_data;
   logic               mask_ok;
   logic               v_we, f_we;

   assign e_idx   = idx_q[IW-1:0];
   assign a_idx   = (op_q == OP_HALVE) ? IW'(off_q + idx_q) : e_idx;
   assign mask_ok = !men_q || m_data[e_idx];
   assign v_we    = busy_q && mask_ok && writes_vreg(op_q);
   assign f_we    = busy_q && mask_ok && (op_q == OP_CMPNE);

   mveu_vrf #(
      .REG_BITS (REG_BITS),
      .NUM_VREGS(NUM_VREGS)
   ) u_vrf (
      .clk    (clk),
      .rst_n  (rst_n),
      .ew     (oew_q),
      .ra_sel (va_q),
      .ra_idx (a_idx),
      .ra_data(a_data),
      .rb_sel (vb_q),
      .rb_idx (e_idx),
      .rb_data(b_data),
      .we     (v_we),
      .w_sel  (vd_q),
      .w_idx  (e_idx),
      .w_data (alu_res),
      .rd_sel (rd_vsel),
      .rd_data(rd_vdata)
   );

   mveu_ffile #(
      .NUM_FREGS(NUM_FREGS),
      .FB       (MAX_MVL)
   ) u_ffile (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (f_we),
      .w_sel  (fd_q),
      .w_idx  (e_idx),
      .w_bit  (alu_neq),
      .m_sel  (msel_q),
      .m_data (m_data),
      .rd_sel (rd_fsel),
      .rd_data(rd_fdata)
   );

   mveu_alu #(
      .HAS_MUL(HAS_MUL)
   ) u_alu (
      .op (op_q),
      .ew (oew_q),
      .a  (a_data),
      .b  (b_data),
      .s  (scal_q),
      .res(alu_res),
      .neq(alu_neq)
   );

   assign busy      = busy_q;
   assign done      = done_q;
   assign cur_vl    = vl_q;
   assign cur_width = ew_q;

endmodule

// File: rtl/mveu_chk.sv
module mveu_chk
   import mveu_pkg::*;
#(
   parameter int REG_BITS = 256,
   parameter int VLW      = 6
) (
   input logic           clk,
   input logic           rst_n,
   input logic           issue_valid,
   input logic           busy,
   input logic           done,
   input logic [VLW-1:0] cur_vl,
   input logic [1:0]     cur_width
);

   // R3
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R3
   start_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(issue_valid));

   // R3
   idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !issue_valid) |=> !busy);

   // R2
   vl_within_mvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cur_vl) <= 32'(mvl_of(REG_BITS, cur_width)));

   // R11
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(cur_vl) && $stable(cur_width)));

endmodule

bind mveu_top mveu_chk #(
   .REG_BITS(REG_BITS),
   .VLW     (VLW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .issue_valid(issue_valid),
   .busy       (busy),
   .done       (done),
   .cur_vl     (cur_vl),
   .cur_width  (cur_width)
);

// File: tb/mveu_top_tb.sv
module mveu_top_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [1:0]   cfg_width = '0;
   logic [5:0]   cfg_vl = '0;
   logic         issue_valid = 1'b0;
   logic [2:0]   issue_op = '0;
   logic [1:0]   issue_vd = '0, issue_va = '0, issue_vb = '0;
   logic [1:0]   issue_fd = '0, issue_mask_sel = '0;
   logic         issue_mask_en = 1'b0;
   logic [63:0]  issue_scalar = '0;
   logic         busy, done;
   logic [5:0]   cur_vl;
   logic [1:0]   cur_width;
   logic [1:0]   rd_vsel = '0, rd_fsel = '0;
   logic [255:0] rd_vdata;
   logic [31:0]  rd_fdata;

   int nchk = 0;
   int nerr = 0;

   // bench model of architectural state
   logic [255:0] mv [4];
   logic [31:0]  mf [4];
   int           vl_m = 0;
   int           ew_m = 0;

   always #4 clk = ~clk;

   mveu_top u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_width(cfg_width), .cfg_vl(cfg_vl),
      .issue_valid(issue_valid), .issue_op(issue_op), .issue_vd(issue_vd),
      .issue_va(issue_va), .issue_vb(issue_vb), .issue_fd(issue_fd),
      .issue_mask_en(issue_mask_en), .issue_mask_sel(issue_mask_sel),
      .issue_scalar(issue_scalar), .busy(busy), .done(done), .cur_vl(cur_vl),
      .cur_width(cur_width), .rd_vsel(rd_vsel), .rd_vdata(rd_vdata),
      .rd_fsel(rd_fsel), .rd_fdata(rd_fdata)
   );

   task automatic chk_eq(input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] msk(int w);
      return (w == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (64 >> w)) - 64'd1);
   endfunction

   function automatic logic [63:0] gel(logic [255:0] v, int i, int w);
      logic [255:0] t;
      t = v >> (i * (64 >> w));
      return t[63:0] & msk(w);
   endfunction

   function automatic logic [255:0] pel(logic [255:0] v, int i, int w, logic [63:0] d);
      for (int k = 0; k < (64 >> w); k++) v[i*(64>>w) + k] = d[k];
      return v;
   endfunction

   // expected effect of an instruction, written from the requirements
   function automatic void model(int op, int vd, int va, int vb, int fd,
                                 bit men, int msel, logic [63:0] s);
      int n, off;
      logic [63:0] a, b, sm, r;
      n   = (op == 5) ? vl_m / 2 : vl_m;
      off = vl_m - n;
      sm  = s & msk(ew_m);
      for (int i = 0; i < n; i++) begin
         if (!men || mf[msel][i]) begin
            a = gel(mv[va], (op == 5) ? off + i : i, ew_m);
            b = gel(mv[vb], i, ew_m);
            case (op)
               0: r = a + b;
               1: r = a - b;
               2: r = sm + a;
               3: r = sm * a;
               default: r = a;
            endcase
            if (op <= 3 || op == 5) mv[vd] = pel(mv[vd], i, ew_m, r & msk(ew_m));
            if (op == 4) mf[fd][i] = (a != b);
         end
      end
   endfunction

   task automatic check_state(input string req);
      for (int r = 0; r < 4; r++) begin
         rd_vsel = 2'(r);
         rd_fsel = 2'(r);
         #1;
         chk_eq(req, $sformatf("vreg %0d", r), rd_vdata, mv[r]);
         chk_eq(req, $sformatf("freg %0d", r), 256'(rd_fdata), 256'(mf[r]));
      end
   endtask

   task automatic do_cfg(input int w, input int vl);
      int cap;
      @(negedge clk);
      cfg_we = 1'b1; cfg_width = 2'(w); cfg_vl = 6'(vl);
      @(negedge clk);
      cfg_we = 1'b0;
      cap  = 4 << w;
      vl_m = (vl > cap) ? cap : vl;
      ew_m = w;
      chk_eq("R2", "cur_vl after config", 256'(cur_vl), 256'(vl_m));
      chk_eq("R2", "cur_width after config", 256'(cur_width), 256'(w));
   endtask

   task automatic run_op(input int op, input int vd, input int va, input int vb,
                         input int fd, input bit men, input int msel,
                         input logic [63:0] s, input string req);
      int n, k, gaps;
      n = (op == 5) ? vl_m / 2 : vl_m;
      @(negedge clk);
      issue_valid = 1'b1; issue_op = 3'(op); issue_vd = 2'(vd); issue_va = 2'(va);
      issue_vb = 2'(vb); issue_fd = 2'(fd); issue_mask_en = men;
      issue_mask_sel = 2'(msel); issue_scalar = s;
      @(negedge clk);
      issue_valid = 1'b0;
      k = 0; gaps = 0;
      while (done !== 1'b1 && k < n + 8) begin
         if (busy !== 1'b1) gaps++;
         @(negedge clk);
         k++;
      end
      chk_eq("R3", "done latency", 256'(k), 256'(n));
      chk_eq("R3", "busy gaps", 256'(gaps), 256'(0));
      chk_eq("R3", "busy low with done", 256'(busy), 256'(0));
      model(op, vd, va, vb, fd, men, msel, s);
      check_state(req);
   endtask

   // fill register r at width w with base+step*i, highest element first
   task automatic load_pat(input int r, input int w, input int base, input int step);
      for (int i = (4 << w) - 1; i >= 0; i--) begin
         do_cfg(w, i + 1);
         run_op(2, r, 0, 0, 0, 1'b0, 0, 64'(base + step * i), "R4");
      end
   endtask

   task automatic t_reset;
      chk_eq("R1", "busy", 256'(busy), 256'(0));
      chk_eq("R1", "done", 256'(done), 256'(0));
      chk_eq("R1", "cur_vl", 256'(cur_vl), 256'(0));
      chk_eq("R1", "cur_width", 256'(cur_width), 256'(0));
      check_state("R1");
   endtask

   task automatic t_cfg;
      do_cfg(0, 9);
      do_cfg(3, 40);
      do_cfg(2, 16);
      do_cfg(1, 5);
      do_cfg(1, 8);
      do_cfg(2, 17);
   endtask

   task automatic t_zero_vl;
      do_cfg(3, 0);
      run_op(2, 1, 0, 0, 0, 1'b0, 0, 64'd5, "R3");
   endtask

   task automatic t_arith;
      load_pat(1, 3, 200, 1);
      load_pat(2, 3, 100, 3);
      do_cfg(3, 32);
      run_op(0, 3, 1, 2, 0, 1'b0, 0, 64'd0, "R5");
      rd_vsel = 2'd3; #1;
      chk_eq("R5", "8-bit add wrap elem0", 256'(gel(rd_vdata, 0, 3)), 256'(44));
      run_op(1, 3, 2, 1, 0, 1'b0, 0, 64'd0, "R5");
      rd_vsel = 2'd3; #1;
      chk_eq("R5", "8-bit sub wrap elem0", 256'(gel(rd_vdata, 0, 3)), 256'(156));
      do_cfg(2, 16);
      run_op(0, 3, 1, 2, 0, 1'b0, 0, 64'd0, "R5");
      rd_vsel = 2'd3; #1;
      chk_eq("R12", "16-bit lanes elem0", 256'(gel(rd_vdata, 0, 2)), 256'(16'h312C));
   endtask

   task automatic t_scalar;
      do_cfg(3, 32);
      run_op(2, 3, 1, 0, 0, 1'b0, 0, 64'h1FF, "R6");
      rd_vsel = 2'd3; #1;
      chk_eq("R6", "scalar add truncated", 256'(gel(rd_vdata, 0, 3)), 256'(199));
      run_op(3, 3, 1, 0, 0, 1'b0, 0, 64'h103, "R6");
      rd_vsel = 2'd3; #1;
      chk_eq("R6", "scalar mul low bits", 256'(gel(rd_vdata, 0, 3)), 256'(88));
      do_cfg(0, 4);
      run_op(3, 3, 1, 0, 0, 1'b0, 0, 64'hFFFF_0000_0000_0003, "R6");
   endtask

   task automatic t_vl;
      do_cfg(3, 32);
      run_op(2, 3, 1, 0, 0, 1'b0, 0, 64'd0, "R4");
      do_cfg(3, 10);
      run_op(0, 3, 1, 2, 0, 1'b0, 0, 64'd0, "R4");
      rd_vsel = 2'd3; #1;
      chk_eq("R4", "elem VL untouched", 256'(gel(rd_vdata, 10, 3)), 256'(210));
      do_cfg(1, 3);
      run_op(1, 3, 3, 2, 0, 1'b0, 0, 64'd0, "R4");
   endtask

   task automatic t_cmp;
      load_pat(3, 3, 200, 1);
      do_cfg(3, 7);
      run_op(2, 3, 1, 0, 0, 1'b0, 0, 64'd1, "R7");
      do_cfg(3, 32);
      run_op(4, 0, 1, 3, 1, 1'b0, 0, 64'd0, "R7");
      rd_fsel = 2'd1; #1;
      chk_eq("R7", "compare flags", 256'(rd_fdata), 256'(32'h0000_007F));
      run_op(4, 0, 1, 2, 2, 1'b0, 0, 64'd0, "R7");
      do_cfg(3, 20);
      run_op(4, 0, 1, 3, 2, 1'b0, 0, 64'd0, "R7");
      rd_fsel = 2'd2; #1;
      chk_eq("R7", "flags beyond VL kept", 256'(rd_fdata), 256'(32'hFFF0_007F));
   endtask

   task automatic t_mask;
      do_cfg(3, 32);
      run_op(2, 3, 1, 0, 0, 1'b0, 0, 64'd0, "R8");
      run_op(0, 3, 1, 2, 0, 1'b1, 1, 64'd0, "R8");
      rd_vsel = 2'd3; #1;
      chk_eq("R8", "flagged elem written", 256'(gel(rd_vdata, 0, 3)), 256'(44));
      chk_eq("R8", "unflagged elem kept", 256'(gel(rd_vdata, 10, 3)), 256'(210));
      run_op(1, 3, 1, 2, 0, 1'b1, 3, 64'd0, "R8");
   endtask

   task automatic t_unmask;
      do_cfg(3, 32);
      run_op(2, 3, 2, 0, 0, 1'b0, 0, 64'd0, "R9");
      rd_vsel = 2'd3; #1;
      chk_eq("R9", "unmasked copy over zero flag reg", rd_vdata, mv[2]);
   endtask

   task automatic t_halve;
      load_pat(1, 1, 1, 1);
      do_cfg(1, 8);
      run_op(5, 3, 1, 0, 0, 1'b0, 0, 64'd0, "R10");
      do_cfg(1, 4);
      run_op(0, 1, 1, 3, 0, 1'b0, 0, 64'd0, "R10");
      run_op(5, 3, 1, 0, 0, 1'b0, 0, 64'd0, "R10");
      do_cfg(1, 2);
      run_op(0, 1, 1, 3, 0, 1'b0, 0, 64'd0, "R10");
      run_op(5, 3, 1, 0, 0, 1'b0, 0, 64'd0, "R10");
      do_cfg(1, 1);
      run_op(0, 1, 1, 3, 0, 1'b0, 0, 64'd0, "R10");
      rd_vsel = 2'd1; #1;
      chk_eq("R10", "reduction result", 256'(gel(rd_vdata, 0, 1)), 256'(36));
      do_cfg(1, 5);
      run_op(5, 3, 2, 0, 0, 1'b0, 0, 64'd0, "R10");
   endtask

   task automatic t_busy;
      int k;
      do_cfg(3, 32);
      @(negedge clk);
      issue_valid = 1'b1; issue_op = 3'd0; issue_vd = 2'd3; issue_va = 2'd1;
      issue_vb = 2'd2; issue_mask_en = 1'b0;
      @(negedge clk);
      issue_op = 3'd1; issue_vd = 2'd2;
      cfg_we = 1'b1; cfg_width = 2'd0; cfg_vl = 6'd1;
      @(negedge clk);
      issue_valid = 1'b0; cfg_we = 1'b0;
      k = 1;
      while (done !== 1'b1 && k < 50) begin
         @(negedge clk);
         k++;
      end
      chk_eq("R11", "latency of first op", 256'(k), 256'(32));
      chk_eq("R11", "cur_vl kept", 256'(cur_vl), 256'(32));
      chk_eq("R11", "cur_width kept", 256'(cur_width), 256'(3));
      @(negedge clk);
      chk_eq("R11", "no second op", 256'(busy), 256'(0));
      model(0, 3, 1, 2, 0, 1'b0, 0, 64'd0);
      check_state("R11");
   endtask

   task automatic t_reserved;
      do_cfg(3, 32);
      run_op(6, 3, 1, 2, 1, 1'b0, 0, 64'd7, "R3");
      run_op(7, 2, 1, 3, 2, 1'b0, 0, 64'd7, "R3");
   endtask

   initial begin
      for (int r = 0; r < 4; r++) begin
         mv[r] = '0;
         mf[r] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg();
      t_zero_vl();
      t_arith();
      t_scalar();
      t_vl();
      t_cmp();
      t_mask();
      t_unmask();
      t_halve();
      t_busy();
      t_reserved();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #(8 * 150000);
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule